// File: doc/BRIEF.md
# Paged Address Translator with User-Mode Access Checking

This block sits between a CPU and its main RAM. It maps logical addresses in the lowest 4 MB onto physical RAM through an internal table of 1024 page descriptors, each 16 bits wide. For every access it also decides whether the access is legal. An illegal access raises a one-cycle bus-error pulse, and for two of the fault kinds it also loads a general-status code. A legal access to a present page sets the accessed or modified bits in that page's descriptor.

Pages are 4 KB. A descriptor holds a 10-bit physical frame number in bits [9:0], a two-bit presence/usage field in bits [14:13] and a write-permission bit in bit 15. The CPU reads and writes descriptors through a separate word-wide table port with byte enables. The high byte of a descriptor is the lower of its two byte addresses. Logical addresses at or above 4 MB are forwarded untranslated and never raise a RAM strobe.

Top module: `page_mmu`

## Requirements
- R1: One cycle after `acc_req` with an address below 0x400000 and no fault, `phys_addr` equals {descriptor bits [9:0], logical bits [11:0]}, with the top two bits zero, and `ram_stb` is high for that one cycle. The descriptor is selected by logical bits [21:12].
- R2: One cycle after `acc_req` with an address at or above 0x400000 in supervisor mode, `phys_addr` equals the logical address, `ram_stb` is low and `bus_err` is low.
- R3: A legal access to a page whose bits [14:13] are nonzero ORs 0x4000 into the descriptor on a read and 0x6000 on a write. A descriptor whose bits [14:13] are zero keeps its value.
- R4: An access with `acc_super` high never raises `bus_err`.
- R5: A user access at or above 0x400000 raises `bus_err` and loads `gstat` with 0xDEFF on a read or 0x9EFF on a write.
- R6: A user access below 0x400000 to a descriptor whose bits [14:13] are zero raises `bus_err` and loads `gstat` with 0xCFFF on a read or 0x8FFF on a write.
- R7: A user access to a present page whose logical bits [22:19] are all zero raises `bus_err` and leaves `gstat` unchanged.
- R8: A user access, read or write, to a present page outside that region whose descriptor bit 15 is clear raises `bus_err` and leaves `gstat` unchanged.
- R9: The user checks are applied in this order, and the first match decides the fault: above 4 MB, then page not present, then low region, then write permission.
- R10: A faulting access changes no descriptor and gives no `ram_stb`. `bus_err` is high for exactly the one cycle after the strobe.
- R11: A table write with `map_we` high updates descriptor `map_idx`. Bit 1 of `map_be` enables bits [15:8] and bit 0 enables bits [7:0]. A table read returns the descriptor on `map_rdata` one cycle later.
- R12: In a cycle with a table write, no status write-back takes place, so the value written through the table port stands.
- R13: During and after reset, `bus_err` and `ram_stb` are low and `gstat` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_req | input | 1 | Access strobe, one cycle per access |
| acc_addr | input | 24 | Logical byte address |
| acc_wr | input | 1 | 1 = write access |
| acc_super | input | 1 | 1 = supervisor mode |
| phys_addr | output | 24 | Registered physical address of the last access |
| ram_stb | output | 1 | One-cycle RAM strobe for a legal translated access |
| bus_err | output | 1 | One-cycle bus-error pulse |
| gstat | output | 16 | Latched general-status code |
| map_req | input | 1 | Table port request |
| map_we | input | 1 | Table port write |
| map_idx | input | 10 | Descriptor index |
| map_be | input | 2 | Byte enables: bit 1 = [15:8], bit 0 = [7:0] |
| map_wdata | input | 16 | Descriptor write data |
| map_rdata | output | 16 | Descriptor read data, one cycle after request |

## Verification
All access results (`phys_addr`, `ram_stb`, `bus_err`, `gstat`) are registered at the first rising edge after the strobe. The bench drives every stimulus on a falling edge and samples at the next falling edge, which is exactly one cycle later. A descriptor's write-back is only observed through a table read issued afterwards, and its data is sampled one falling edge after that read. The bench samples one cycle further on to confirm that the bus error lasts a single cycle.

// File: rtl/page_mmu.sv
module page_mmu #(
  parameter int ADDR_W   = 24,
  parameter int PAGE_W   = 10,
  parameter int OFF_W    = 12,
  parameter int KERN_LSB = 19,
  parameter logic [15:0] CODE_RD_PF = 16'hCFFF,
  parameter logic [15:0] CODE_RD_NM = 16'hDEFF,
  parameter logic [15:0] CODE_WR_PF = 16'h8FFF,
  parameter logic [15:0] CODE_WR_NM = 16'h9EFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_req,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_wr,
  input  logic              acc_super,
  output logic [ADDR_W-1:0] phys_addr,
  output logic              ram_stb,
  output logic              bus_err,
  output logic [15:0]       gstat,
  input  logic              map_req,
  input  logic              map_we,
  input  logic [PAGE_W-1:0] map_idx,
  input  logic [1:0]        map_be,
  input  logic [15:0]       map_wdata,
  output logic [15:0]       map_rdata
);
  localparam int RAM_W = PAGE_W + OFF_W;
  localparam int DEPTH = 1 << PAGE_W;
  localparam int HI_W  = ADDR_W - RAM_W;

  logic [15:0] map_q [DEPTH];

  logic [PAGE_W-1:0] pg;
  logic [15:0]       ent;
  logic in_ram, present, low_region;
  logic f_nm, f_pf, f_kn, f_we, fault, tbl_wr, touch;

  assign pg         = acc_addr[RAM_W-1:OFF_W];
  assign ent        = map_q[pg];
  assign in_ram     = (acc_addr[ADDR_W-1:RAM_W] == '0);
  assign present    = |ent[14:13];
  assign low_region = (acc_addr[RAM_W:KERN_LSB] == '0);

  assign f_nm  = !acc_super && !in_ram;
  assign f_pf  = !acc_super && in_ram && !present;
  assign f_kn  = !acc_super && in_ram && present && low_region;
  assign f_we  = !acc_super && in_ram && present && !low_region && !ent[15];
  assign fault = f_nm | f_pf | f_kn | f_we;

  assign tbl_wr = map_req && map_we;
  assign touch  = acc_req && !fault && in_ram && present && !tbl_wr;

  always_ff @(posedge clk) begin
    if (tbl_wr) begin
      if (map_be[1]) map_q[map_idx][15:8] <= map_wdata[15:8];
      if (map_be[0]) map_q[map_idx][7:0]  <= map_wdata[7:0];
    end else if (touch) begin
      map_q[pg] <= ent | (acc_wr ? 16'h6000 : 16'h4000);
    end
    if (map_req && !map_we) map_rdata <= map_q[map_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phys_addr <= '0;
      ram_stb   <= 1'b0;
      bus_err   <= 1'b0;
      gstat     <= 16'h0000;
    end else begin
      ram_stb <= acc_req && !fault && in_ram;
      bus_err <= acc_req && fault;
      if (acc_req)
        phys_addr <= in_ram ? {{HI_W{1'b0}}, ent[PAGE_W-1:0], acc_addr[OFF_W-1:0]} : acc_addr;
      if (acc_req && f_nm)
        gstat <= acc_wr ? CODE_WR_NM : CODE_RD_NM;
      else if (acc_req && f_pf)
        gstat <= acc_wr ? CODE_WR_PF : CODE_RD_PF;
    end
  end

  // R4
  super_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && acc_super |=> !bus_err);

  // R5
  nonmem_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && !acc_super && (acc_addr[ADDR_W-1:RAM_W] != '0)
    |=> bus_err && gstat == ($past(acc_wr) ? CODE_WR_NM : CODE_RD_NM));

  // R10
  excl_stb_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_err && ram_stb));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_req |=> !bus_err && !ram_stb && $stable(gstat));

  // R1
  offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req |=> phys_addr[OFF_W-1:0] == $past(acc_addr[OFF_W-1:0]));
endmodule

// File: tb/page_mmu_bench.sv
module page_mmu_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic acc_req = 0, acc_wr = 0, acc_super = 0;
  logic [23:0] acc_addr = '0;
  logic [23:0] phys_addr;
  logic ram_stb, bus_err;
  logic [15:0] gstat;
  logic map_req = 0, map_we = 0;
  logic [9:0] map_idx = '0;
  logic [1:0] map_be = '0;
  logic [15:0] map_wdata = '0, map_rdata;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_mmu u_page_mmu (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_addr(acc_addr),
    .acc_wr(acc_wr), .acc_super(acc_super), .phys_addr(phys_addr),
    .ram_stb(ram_stb), .bus_err(bus_err), .gstat(gstat),
    .map_req(map_req), .map_we(map_we), .map_idx(map_idx), .map_be(map_be),
    .map_wdata(map_wdata), .map_rdata(map_rdata));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tbl_write(input logic [9:0] idx, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    map_req = 1; map_we = 1; map_idx = idx; map_be = be; map_wdata = d;
    @(negedge clk);
    map_req = 0; map_we = 0;
  endtask

  task automatic tbl_check(input string tag, input logic [9:0] idx, input logic [15:0] exp);
    @(negedge clk);
    map_req = 1; map_we = 0; map_idx = idx;
    @(negedge clk);
    map_req = 0;
    chk(tag, map_rdata, exp);
  endtask

  // issues one access and returns at the negedge where its results are due
  task automatic access(input logic [23:0] a, input logic wr, input logic sup);
    @(negedge clk);
    acc_req = 1; acc_addr = a; acc_wr = wr; acc_super = sup;
    @(negedge clk);
    acc_req = 0;
  endtask

  task automatic expect_ok(input string tag, input logic [23:0] pa, input logic stb);
    chk({tag, " phys"}, phys_addr, pa);
    chk({tag, " stb"}, ram_stb, stb);
    chk({tag, " err"}, bus_err, 0);
  endtask

  task automatic expect_fault(input string tag, input logic [15:0] st);
    chk({tag, " err"}, bus_err, 1);
    chk({tag, " stb"}, ram_stb, 0);
    chk({tag, " gstat"}, gstat, st);
    @(negedge clk);
    chk({tag, " pulse R10"}, bus_err, 0);
  endtask

  task automatic t_reset;
    chk("R13 err", bus_err, 0);
    chk("R13 stb", ram_stb, 0);
    chk("R13 gstat", gstat, 16'h0000);
  endtask

  task automatic t_table_port;
    tbl_write(10'h005, 2'b11, 16'hABCD);
    tbl_check("R11 full word", 10'h005, 16'hABCD);
    tbl_write(10'h005, 2'b01, 16'h5512);
    tbl_check("R11 low byte", 10'h005, 16'hAB12);
    tbl_write(10'h005, 2'b10, 16'h3477);
    tbl_check("R11 high byte", 10'h005, 16'h3412);
  endtask

  task automatic t_translate;
    tbl_write(10'h100, 2'b11, 16'hA2A5);
    access(24'h100ABC, 0, 0);
    expect_ok("R1 user read", 24'h2A5ABC, 1);
    tbl_check("R3 read sets accessed", 10'h100, 16'hE2A5);
    tbl_write(10'h101, 2'b11, 16'hA123);
    access(24'h101FFF, 1, 0);
    expect_ok("R1 user write", 24'h123FFF, 1);
    tbl_check("R3 write sets dirty", 10'h101, 16'hE123);
  endtask

  task automatic t_passthrough;
    access(24'h420010, 1, 1);
    expect_ok("R2 supervisor high", 24'h420010, 0);
  endtask

  task automatic t_nonmem;
    access(24'h500000, 0, 0);
    expect_fault("R5 read", 16'hDEFF);
    access(24'hE43000, 1, 0);
    expect_fault("R5 write", 16'h9EFF);
  endtask

  task automatic t_pagefault;
    tbl_write(10'h102, 2'b11, 16'h8055);
    access(24'h102010, 0, 0);
    expect_fault("R6 read", 16'hCFFF);
    access(24'h102020, 1, 0);
    expect_fault("R6 write", 16'h8FFF);
    tbl_check("R3 R10 absent entry kept", 10'h102, 16'h8055);
  endtask

  task automatic t_kernel;
    tbl_write(10'h010, 2'b11, 16'hA011);
    access(24'h010000, 0, 0);
    expect_fault("R7 low region", 16'h8FFF);
    tbl_check("R10 kernel no writeback", 10'h010, 16'hA011);
  endtask

  task automatic t_nowe;
    tbl_write(10'h103, 2'b11, 16'h2033);
    access(24'h103004, 1, 0);
    expect_fault("R8 write", 16'h8FFF);
    access(24'h103008, 0, 0);
    expect_fault("R8 read", 16'h8FFF);
    tbl_check("R10 nowe no writeback", 10'h103, 16'h2033);
  endtask

  task automatic t_priority;
    tbl_write(10'h011, 2'b11, 16'h0000);
    access(24'h011000, 0, 0);
    expect_fault("R9 absent before low region", 16'hCFFF);
    tbl_write(10'h104, 2'b11, 16'h0000);
    access(24'h104000, 1, 0);
    expect_fault("R9 absent before write permission", 16'h8FFF);
  endtask

  task automatic t_supervisor;
    access(24'h102ABC, 0, 1);
    expect_ok("R4 super absent page", 24'h055ABC, 1);
    tbl_check("R3 super absent kept", 10'h102, 16'h8055);
    tbl_write(10'h012, 2'b11, 16'h2044);
    access(24'h012345, 1, 1);
    expect_ok("R4 super low no-we", 24'h044345, 1);
    tbl_check("R3 super write dirty", 10'h012, 16'h6044);
  endtask

  task automatic t_port_wins;
    tbl_write(10'h105, 2'b11, 16'hA001);
    @(negedge clk);
    acc_req = 1; acc_addr = 24'h105010; acc_wr = 1; acc_super = 0;
    map_req = 1; map_we = 1; map_idx = 10'h105; map_be = 2'b11; map_wdata = 16'hA0FF;
    @(negedge clk);
    acc_req = 0; map_req = 0; map_we = 0;
    expect_ok("R12 access same cycle", 24'h001010, 1);
    tbl_check("R12 port value stands", 10'h105, 16'hA0FF);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_table_port();
    t_translate();
    t_passthrough();
    t_nonmem();
    t_pagefault();
    t_kernel();
    t_nowe();
    t_priority();
    t_supervisor();
    t_port_wins();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule